// File: doc/BRIEF.md
# Prioritized Interrupt Offset Register

This block keeps three pending-flag vectors (bus-error, request-lost and buffer-full) for 16 transfer sources. A per-source line-select bit routes each source to one of two interrupt lines, and this block serves line 0 only. A combinational selector finds the single most urgent pending source routed to line 0. It reports that source in a read-only status word that gives the interrupt category and the source index. It also raises the line-0 interrupt output while anything is pending.

Software services the line by reading the status word. When the read covers the low byte lane, the one flag behind the reported interrupt is cleared. The next pending source then becomes visible on the following cycle. While debug mode is asserted, reads have no side effect. The transfer engine sets flags through one-cycle set pulses, one vector per category.

Top module: `irq_off_reg`

## Requirements
- R1: After reset all flags are clear, `rd_data_o` is 0 and `irq_line0_o` is low.
- R2: Only sources whose `line_map_i` bit is 0 take part in the selection. A flag on a source mapped to line 1 stays pending, and it becomes selectable once its map bit returns to 0.
- R3: Category priority from highest to lowest is bus-error, then request-lost, then buffer-full.
- R4: Within one category, the pending source with the lowest index wins.
- R5: `rd_data_o[9:8]` holds the category code: 0 none, 1 buffer-full, 2 request-lost, 3 bus-error. `rd_data_o[3:0]` holds the source index, where index 2n is pair n sub-channel A and 2n+1 is pair n sub-channel B.
- R6: `rd_data_o[31:10]` and `rd_data_o[7:4]` always read 0.
- R7: A read with `rd_be_i[0]`=1 clears only the reported flag, in the vector of the reported category, at the clock edge of the read. A read with `rd_be_i[0]`=0 clears nothing.
- R8: With `dbg_mode_i`=1, a read leaves every flag unchanged.
- R9: With nothing pending, the index field reads 0 and a read clears nothing.
- R10: If a set pulse and a read-clear hit the same flag in one cycle, the flag stays set.
- R11: `irq_line0_o` is 1 exactly when `rd_data_o[9:8]` is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| dbg_mode_i | input | 1 | Debug mode: reads have no side effect |
| line_map_i | input | 16 | Per-source line select, 0 = line 0 |
| berr_set_i | input | 16 | Bus-error flag set pulses |
| rlost_set_i | input | 16 | Request-lost flag set pulses |
| bfull_set_i | input | 16 | Buffer-full flag set pulses |
| rd_en_i | input | 1 | Status word read strobe |
| rd_be_i | input | 4 | Byte-lane enables of the read |
| rd_data_o | output | 32 | Status word: category and source index |
| irq_line0_o | output | 1 | Line-0 interrupt request |

## Verification
The hardest state to reach from the ports is a flag that is pending but cannot be seen. This happens to a source routed to line 1, or to a flag shadowed by a higher-priority winner. A wrong clear or a missed set of such a flag leaves the status word unchanged. To expose it, the stimulus parks flags behind line-1 map bits and behind higher categories. It then performs plain reads, reads with the low lane off, and debug reads. Finally it drains the line read by read and flips the map bits back, so every hidden flag must surface in the exact expected order.

// File: rtl/irq_off_pkg.sv
package irq_off_pkg;
  parameter int NUM_CAT = 3;
  // category slots, listed in priority order
  parameter int CAT_BERR  = 0;
  parameter int CAT_RLOST = 1;
  parameter int CAT_BFULL = 2;

  typedef enum logic [1:0] {
    TYP_NONE  = 2'd0,
    TYP_BFULL = 2'd1,
    TYP_RLOST = 2'd2,
    TYP_BERR  = 2'd3
  } irq_type_e;

  function automatic irq_type_e cat_code(input int cat);
    case (cat)
      CAT_BERR:  return TYP_BERR;
      CAT_RLOST: return TYP_RLOST;
      CAT_BFULL: return TYP_BFULL;
      default:   return TYP_NONE;
    endcase
  endfunction
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int NUM_SRC = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] set_i,
  input  logic [NUM_SRC-1:0] clr_i,
  output logic [NUM_SRC-1:0] flags_o
);
  // set beats clear on the same bit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_o <= '0;
    else         flags_o <= (flags_o & ~clr_i) | set_i;
  end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int NUM_SRC = 16,
  localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic [NUM_SRC-1:0] req_i,
  output logic               vld_o,
  output logic [IDX_W-1:0]   idx_o
);
  // lowest index wins
  always_comb begin
    vld_o = 1'b0;
    idx_o = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        vld_o = 1'b1;
        idx_o = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_off_reg.sv
module irq_off_reg
  import irq_off_pkg::*;
#(
  parameter int NUM_SRC  = 16,
  parameter int DATA_W   = 32,
  parameter int TYPE_LSB = 8,
  parameter int IDX_LSB  = 0,
  localparam int IDX_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
  localparam int BE_W    = DATA_W / 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               dbg_mode_i,
  input  logic [NUM_SRC-1:0] line_map_i,
  input  logic [NUM_SRC-1:0] berr_set_i,
  input  logic [NUM_SRC-1:0] rlost_set_i,
  input  logic [NUM_SRC-1:0] bfull_set_i,
  input  logic               rd_en_i,
  input  logic [BE_W-1:0]    rd_be_i,
  output logic [DATA_W-1:0]  rd_data_o,
  output logic               irq_line0_o
);
  localparam int IDX_LANE = IDX_LSB / 8;

  logic [NUM_CAT-1:0][NUM_SRC-1:0] set_vec, clr_vec, flg_vec;
  logic [NUM_CAT-1:0]              cat_vld;
  logic [NUM_CAT-1:0][IDX_W-1:0]   cat_idx;

  always_comb begin
    set_vec            = '0;
    set_vec[CAT_BERR]  = berr_set_i;
    set_vec[CAT_RLOST] = rlost_set_i;
    set_vec[CAT_BFULL] = bfull_set_i;
  end

  for (genvar c = 0; c < NUM_CAT; c++) begin : g_cat
    irq_flag_bank #(.NUM_SRC(NUM_SRC)) u_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .set_i   (set_vec[c]),
      .clr_i   (clr_vec[c]),
      .flags_o (flg_vec[c])
    );
    irq_prio_pick #(.NUM_SRC(NUM_SRC)) u_pick (
      .req_i (flg_vec[c] & ~line_map_i),
      .vld_o (cat_vld[c]),
      .idx_o (cat_idx[c])
    );
  end

  // category arbitration: lower slot wins
  logic             win_any;
  logic [1:0]       win_cat;
  logic [IDX_W-1:0] win_idx;
  irq_type_e        win_type;

  always_comb begin
    win_any = 1'b0;
    win_cat = '0;
    win_idx = '0;
    for (int c = NUM_CAT - 1; c >= 0; c--) begin
      if (cat_vld[c]) begin
        win_any = 1'b1;
        win_cat = 2'(c);
        win_idx = cat_idx[c];
      end
    end
    win_type = win_any ? cat_code(int'(win_cat)) : TYP_NONE;
  end

  // acknowledge only when the lane carrying the index is read
  logic ack;
  assign ack = rd_en_i & rd_be_i[IDX_LANE] & ~dbg_mode_i & win_any;

  always_comb begin
    clr_vec = '0;
    for (int c = 0; c < NUM_CAT; c++) begin
      if (ack && (int'(win_cat) == c)) clr_vec[c][win_idx] = 1'b1;
    end
  end

  always_comb begin
    rd_data_o                       = '0;
    rd_data_o[TYPE_LSB +: 2]        = win_type;
    rd_data_o[IDX_LSB +: IDX_W]     = win_idx;
  end

  assign irq_line0_o = win_any;
endmodule

// File: rtl/irq_off_chk.sv
module irq_off_chk #(
  parameter int NUM_SRC = 16,
  parameter int DATA_W  = 32,
  parameter int BE_W    = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               dbg_mode_i,
  input logic [NUM_SRC-1:0] line_map_i,
  input logic [NUM_SRC-1:0] berr_set_i,
  input logic [NUM_SRC-1:0] rlost_set_i,
  input logic [NUM_SRC-1:0] bfull_set_i,
  input logic               rd_en_i,
  input logic [BE_W-1:0]    rd_be_i,
  input logic [DATA_W-1:0]  rd_data_o,
  input logic               irq_line0_o
);
  logic no_set;
  assign no_set = (berr_set_i == '0) && (rlost_set_i == '0) && (bfull_set_i == '0);

  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o[DATA_W-1:10] == '0) && (rd_data_o[7:4] == '0)); // R6

  AST_IRQ_FOLLOWS_TYPE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_line0_o == (rd_data_o[9:8] != 2'd0)); // R11

  AST_IDLE_IDX_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o[9:8] == 2'd0) |-> (rd_data_o[3:0] == 4'd0)); // R9

  AST_DBG_NO_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && dbg_mode_i && no_set) |=>
      ((line_map_i != $past(line_map_i)) || (rd_data_o == $past(rd_data_o)))); // R8

  AST_NOLANE_NO_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !rd_be_i[0] && no_set) |=>
      ((line_map_i != $past(line_map_i)) || (rd_data_o == $past(rd_data_o)))); // R7

  AST_CLEAR_ADVANCES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && rd_be_i[0] && !dbg_mode_i && irq_line0_o && no_set) |=>
      ((line_map_i != $past(line_map_i)) || (rd_data_o != $past(rd_data_o)))); // R7
endmodule

bind irq_off_reg irq_off_chk #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .BE_W(BE_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .dbg_mode_i  (dbg_mode_i),
  .line_map_i  (line_map_i),
  .berr_set_i  (berr_set_i),
  .rlost_set_i (rlost_set_i),
  .bfull_set_i (bfull_set_i),
  .rd_en_i     (rd_en_i),
  .rd_be_i     (rd_be_i),
  .rd_data_o   (rd_data_o),
  .irq_line0_o (irq_line0_o)
);

// File: tb/sim_irq_off_reg.sv
`timescale 1ns/1ps
module sim_irq_off_reg;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        dbg_mode_i = 1'b0;
  logic [15:0] line_map_i = '0;
  logic [15:0] berr_set_i = '0, rlost_set_i = '0, bfull_set_i = '0;
  logic        rd_en_i = 1'b0;
  logic [3:0]  rd_be_i = '0;
  logic [31:0] rd_data_o;
  logic        irq_line0_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // model flags: row 0 bus-error, 1 request-lost, 2 buffer-full
  bit mf [3][16];

  always #4 clk_i = ~clk_i;

  irq_off_reg u0 (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] exp_word();
    for (int c = 0; c < 3; c++)
      for (int i = 0; i < 16; i++)
        if (mf[c][i] && !line_map_i[i]) return ((32'(3 - c)) << 8) | 32'(i);
    return 32'h0;
  endfunction

  // one cycle: drive at negedge, compare, advance model at posedge
  task automatic step(input string tag, input logic [15:0] sb, input logic [15:0] sr,
                      input logic [15:0] sf, input bit rd, input logic [3:0] be, input bit dbg);
    logic [31:0] e;
    berr_set_i = sb; rlost_set_i = sr; bfull_set_i = sf;
    rd_en_i = rd; rd_be_i = be; dbg_mode_i = dbg;
    #1;
    e = exp_word();
    chk(rd_data_o === e, tag, rd_data_o, e);
    chk(irq_line0_o === (e[9:8] != 0), "R11", 32'(irq_line0_o), 32'(e[9:8] != 0));
    if (rd && be[0] && !dbg && e[9:8] != 0) mf[3 - int'(e[9:8])][e[3:0]] = 0;
    for (int i = 0; i < 16; i++) begin
      if (sb[i]) mf[0][i] = 1;
      if (sr[i]) mf[1][i] = 1;
      if (sf[i]) mf[2][i] = 1;
    end
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic idle(input string tag);
    step(tag, '0, '0, '0, 0, 4'h0, 0);
  endtask

  task automatic rd(input string tag);
    step(tag, '0, '0, '0, 1, 4'hF, 0);
  endtask

  task automatic expect_now(input string tag, input logic [31:0] e);
    #1;
    chk(rd_data_o === e, tag, rd_data_o, e);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=%h exp=%h", 32'h0, 32'h1);
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < 3; c++) for (int i = 0; i < 16; i++) mf[c][i] = 0;
    berr_set_i = 16'hFFFF;
    #20;
    chk(rd_data_o === 32'h0, "R1 reset word", rd_data_o, 32'h0);
    chk(irq_line0_o === 1'b0, "R1 reset irq", 32'(irq_line0_o), 32'h0);
    berr_set_i = '0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    idle("R1");

    // R3 category order, R5 codes
    step("R3 load", 16'h0200, 16'h0020, 16'h0004, 0, 4'h0, 0);
    expect_now("R3 berr first", 32'h0000_0309);
    rd("R3");
    expect_now("R3 rlost second", 32'h0000_0205);
    rd("R3");
    expect_now("R5 bfull code", 32'h0000_0102);
    rd("R5");
    expect_now("R9 drained", 32'h0);

    // R9 empty read clears nothing
    rd("R9");
    idle("R9");

    // R4 index order, R5 sub-channel B index
    step("R4 load", 16'h400A, '0, '0, 0, 4'h0, 0);
    expect_now("R4 lowest", 32'h0000_0301);
    rd("R4");
    expect_now("R4 next B", 32'h0000_0303);
    rd("R4");
    expect_now("R4 last", 32'h0000_030E);
    rd("R4");

    // R2 line-1 sources hidden and kept
    line_map_i = 16'h0003;
    step("R2 load", 16'h0001, '0, 16'h0012, 0, 4'h0, 0);
    expect_now("R2 masked", 32'h0000_0104);
    rd("R2");
    expect_now("R2 none on line0", 32'h0);
    rd("R2");
    line_map_i = 16'h0000;
    expect_now("R2 revealed berr", 32'h0000_0300);
    rd("R2");
    expect_now("R2 revealed bfull", 32'h0000_0101);
    rd("R2");

    // R8 debug read, R7 lane gating
    step("R8 load", '0, 16'h0100, '0, 0, 4'h0, 0);
    step("R8 dbg rd", '0, '0, '0, 1, 4'hF, 1);
    expect_now("R8 kept", 32'h0000_0208);
    step("R7 no lane0", '0, '0, '0, 1, 4'hE, 0);
    expect_now("R7 kept", 32'h0000_0208);
    step("R7 lane0 only", '0, '0, '0, 1, 4'h1, 0);
    expect_now("R7 cleared", 32'h0);

    // R10 set wins over clear
    step("R10 load", '0, '0, 16'h0040, 0, 4'h0, 0);
    step("R10 collide", '0, '0, 16'h0040, 1, 4'hF, 0);
    expect_now("R10 still set", 32'h0000_0106);
    rd("R10");
    expect_now("R10 gone", 32'h0);

    // random mix
    for (int k = 0; k < 4000; k++) begin
      logic [15:0] a, b, f;
      a = 16'($urandom) & 16'($urandom) & 16'($urandom);
      b = 16'($urandom) & 16'($urandom) & 16'($urandom);
      f = 16'($urandom) & 16'($urandom) & 16'($urandom);
      if ($urandom_range(0, 3) != 0) begin a = '0; b = '0; f = '0; end
      if (k % 500 == 0) line_map_i = 16'($urandom) & 16'($urandom);
      step("RND R2 R3 R4 R7 R8 R10", a, b, f, 1'($urandom_range(0, 1)),
           4'($urandom), ($urandom_range(0, 7) == 0));
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule